// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. A programmable load value feeds a down-counter. The counter only moves on cycles where an external tick strobe is high, so the watchdog can run from a slow tick taken from the bus clock.

When the counter expires the first time, the block raises a level interrupt and restarts the count from the load value. If that interrupt is still pending when the count expires again, and the reset stage is enabled, a reset request asserts. The reset request stays high until the block's own system reset. Software keeps the watchdog quiet by writing the kick register. A kick drops the interrupt and restarts the count.

Every configuration write passes through a lock. The lock opens only when the key value 0x1ACCE551 is written to it. Any other value closes it again.

Top module: `lockwd_top`

## Requirements
- R1: After reset the lock register reads 1, the load register reads 0xFFFFFFFF, the control register reads 0, and both the interrupt and the reset request are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0. Writing any other value there locks the block, and the lock register then reads 1.
- R3: While the block is locked, writes to the load register (0x000), the control register (0x008) and the kick register (0x00C) have no effect on readback, on the interrupt or on the count.
- R4: Offset 0x000 reads back the full load value. Offset 0x008 reads the run bit in bit 0 and the reset-enable bit in bit 1, with all other bits 0. The kick offset and any unmapped offset read 0.
- R5: The counter moves only on cycles where tick_en is high and the run bit is 1. With load value L, the interrupt rises in the cycle after the (L+1)-th such strobe following a restart.
- R6: The interrupt is a level that stays high until it is cleared. After the first expiry the count restarts from the load value. A second expiry while the interrupt is still pending asserts the reset request when the reset-enable bit is 1.
- R7: When the reset-enable bit is 0, a second expiry leaves the reset request low and the interrupt high.
- R8: A write of any data to the kick register clears the interrupt and restarts the count from the load value. If a kick and an expiry fall in the same cycle, the kick wins.
- R9: Writing 0 to the run bit stops the count and drops the interrupt, so that no interrupt and no reset request appear afterwards.
- R10: Once asserted, the reset request stays high through kicks and stops. Only the block's system reset clears it.
- R11: A load value of 0 with the run bit set expires on the first tick strobe.
- R12: Writing the load register, or setting the run bit from 0 to 1, restarts the count from the load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| tick_en | input | 1 | Count strobe; the counter moves only when this is high |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt raised at the first expiry |
| wdt_rst_o | output | 1 | Sticky reset request raised at the second expiry |

## Verification
The assertions take for granted that each bus write is a single-cycle strobe on a stable address. They also assume that tick_en is a clean synchronous level and that no write happens during reset. The checks that tie a lock-register write to the next lock state rely on that write being the only one in its cycle. The directed stimulus drives every input on the falling edge and raises the write strobe for exactly one rising edge. It holds writes and ticks low around reset and overlaps a tick with a write only in the scenario that tests a kick racing an expiry.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

    localparam int unsigned BUS_AW = 12;

    localparam logic [BUS_AW-1:0] OFS_LOAD = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_KICK = 12'h00C;
    localparam logic [BUS_AW-1:0] OFS_LOCK = 12'hC00;

    // bit 0 = run, bit 1 = reset stage enable
    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/lockwd_regs.sv
module lockwd_regs
    import lockwd_pkg::*;
#(
    parameter int unsigned          DATA_W    = 32,
    parameter logic [DATA_W-1:0]    KEY       = 32'h1ACCE551,
    parameter logic [DATA_W-1:0]    LOAD_INIT = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W-1:0]   load_next,
    output ctrl_t               ctrl_q_o,
    output logic                locked_o,
    output logic                kick_o,
    output logic                reload_o
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic               locked;
        logic [DATA_W-1:0]  load;
        ctrl_t              ctrl;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit_load, hit_ctrl, hit_kick, hit_lock;
    logic  kick_d, reload_d;

    always_comb begin
        hit_load = we && (addr == OFS_LOAD);
        hit_ctrl = we && (addr == OFS_CTRL);
        hit_kick = we && (addr == OFS_KICK);
        hit_lock = we && (addr == OFS_LOCK);

        st_d     = st_q;
        kick_d   = 1'b0;
        reload_d = 1'b0;

        if (hit_lock) begin
            st_d.locked = (wdata != KEY);
        end

        if (!st_q.locked) begin
            if (hit_load) begin
                st_d.load = wdata;
                reload_d  = 1'b1;
            end
            if (hit_ctrl) begin
                st_d.ctrl.run    = wdata[0];
                st_d.ctrl.rst_en = wdata[1];
                if (wdata[0] && !st_q.ctrl.run) begin
                    reload_d = 1'b1;
                end
            end
            if (hit_kick) begin
                kick_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{locked: 1'b1, load: LOAD_INIT, ctrl: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            OFS_LOAD: rdata = st_q.load;
            OFS_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, st_q.ctrl};
            OFS_LOCK: rdata = {{(DATA_W-1){1'b0}}, st_q.locked};
            default:  rdata = '0;
        endcase
    end

    assign load_next = st_d.load;
    assign ctrl_q_o  = st_q.ctrl;
    assign locked_o  = st_q.locked;
    assign kick_o    = kick_d;
    assign reload_o  = reload_d;

endmodule

// File: rtl/lockwd_core.sv
module lockwd_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              rst_en,
    input  logic              kick,
    input  logic              reload,
    input  logic [CNT_W-1:0]  reload_val,
    output logic              irq_o,
    output logic              rst_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             fired;
    } core_t;

    core_t cs_d, cs_q;
    logic  at_zero;

    always_comb begin
        cs_d    = cs_q;
        at_zero = (cs_q.cnt == '0);

        if (!run) begin
            cs_d.irq = 1'b0;
        end

        if (kick) begin
            cs_d.cnt = reload_val;
            cs_d.irq = 1'b0;
        end else if (reload) begin
            cs_d.cnt = reload_val;
        end else if (run && tick) begin
            if (at_zero) begin
                cs_d.cnt = reload_val;
                if (!cs_q.irq) begin
                    cs_d.irq = 1'b1;
                end else if (rst_en) begin
                    cs_d.fired = 1'b1;
                end
            end else begin
                cs_d.cnt = cs_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{cnt: '1, irq: 1'b0, fired: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign irq_o = cs_q.irq;
    assign rst_o = cs_q.fired;

endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
    import lockwd_pkg::*;
#(
    parameter int unsigned          DATA_W    = 32,
    parameter logic [DATA_W-1:0]    KEY       = 32'h1ACCE551,
    parameter logic [DATA_W-1:0]    LOAD_INIT = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [11:0]         bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_o,
    output logic                wdt_rst_o
);

    ctrl_t              ctrl_q;
    logic [DATA_W-1:0]  load_next;
    logic               locked;
    logic               kick;
    logic               reload;
    logic               ctrl_run;

    lockwd_regs #(
        .DATA_W    (DATA_W),
        .KEY       (KEY),
        .LOAD_INIT (LOAD_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .load_next (load_next),
        .ctrl_q_o  (ctrl_q),
        .locked_o  (locked),
        .kick_o    (kick),
        .reload_o  (reload)
    );

    assign ctrl_run = ctrl_q.run;

    lockwd_core #(
        .CNT_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .run        (ctrl_q.run),
        .rst_en     (ctrl_q.rst_en),
        .kick       (kick),
        .reload     (reload),
        .reload_val (load_next),
        .irq_o      (irq_o),
        .rst_o      (wdt_rst_o)
    );

endmodule

// File: rtl/lockwd_chk.sv
module lockwd_chk #(
    parameter int unsigned          DATA_W = 32,
    parameter logic [DATA_W-1:0]    KEY    = 32'h1ACCE551
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [11:0]        bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               irq_o,
    input  logic               wdt_rst_o,
    input  logic               locked,
    input  logic               ctrl_run
);

    logic lock_wr, kick_wr, cfg_wr_locked;

    assign lock_wr       = bus_we && (bus_addr == 12'hC00);
    assign kick_wr       = bus_we && (bus_addr == 12'h00C);
    assign cfg_wr_locked = locked && bus_we &&
                           ((bus_addr == 12'h000) || (bus_addr == 12'h008));

    AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> (locked == ($past(bus_wdata) != KEY))); // R2

    AST_LOCKED_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_locked && bus_addr == 12'h000) |=> $stable(bus_rdata)); // R3

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_en)); // R5

    AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> ($past(irq_o) && $past(tick_en))); // R6

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_wr && !locked) |=> !irq_o); // R8

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_run |=> !irq_o); // R9

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> wdt_rst_o); // R10

endmodule

bind lockwd_top lockwd_chk #(
    .DATA_W (DATA_W),
    .KEY    (KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wdt_rst_o (wdt_rst_o),
    .locked    (locked),
    .ctrl_run  (ctrl_run)
);

// File: tb/lockwd_top_tb.sv
`timescale 1ns/1ps
module lockwd_top_tb;

    localparam logic [31:0] KEY      = 32'h1ACCE551;
    localparam logic [11:0] A_LOAD   = 12'h000;
    localparam logic [11:0] A_CTRL   = 12'h008;
    localparam logic [11:0] A_KICK   = 12'h00C;
    localparam logic [11:0] A_LOCK   = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lockwd_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .wdt_rst_o (wdt_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        rd(A_LOCK, 32'd1, "R1 lock after reset");
        rd(A_LOAD, 32'hFFFFFFFF, "R1 load after reset");
        rd(A_CTRL, 32'd0, "R1 ctrl after reset");
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R1 rst after reset", {31'd0, wdt_rst_o}, 32'd0);
        rd(A_KICK, 32'd0, "R4 kick offset reads 0");
        rd(12'h004, 32'd0, "R4 unmapped reads 0");
    endtask

    task automatic t_lock();
        wr(A_LOCK, KEY);
        rd(A_LOCK, 32'd0, "R2 key unlocks");
        wr(A_LOCK, 32'h1);
        rd(A_LOCK, 32'd1, "R2 value 1 locks");
        wr(A_LOCK, KEY);
        wr(A_LOCK, KEY ^ 32'h100);
        rd(A_LOCK, 32'd1, "R2 near-key locks");
        wr(A_LOAD, 32'h55);
        rd(A_LOAD, 32'hFFFFFFFF, "R3 locked load write ignored");
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, 32'd0, "R3 locked ctrl write ignored");
        ticks(3);
        chk("R3 no count while locked-off", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_count();
        wr(A_LOCK, KEY);
        wr(A_LOAD, 32'hA5A50004);
        rd(A_LOAD, 32'hA5A50004, "R4 load readback");
        wr(A_LOAD, 32'd4);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, 32'd1, "R4 ctrl readback");
        repeat (10) @(negedge clk);
        chk("R5 no move without tick", {31'd0, irq_o}, 32'd0);
        ticks(4);
        chk("R5 quiet after L strobes", {31'd0, irq_o}, 32'd0);
        ticks(1);
        chk("R5 irq on L+1 strobe", {31'd0, irq_o}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R6 irq level held", {31'd0, irq_o}, 32'd1);
        ticks(5);
        chk("R7 no reset when disabled", {31'd0, wdt_rst_o}, 32'd0);
        chk("R7 irq still pending", {31'd0, irq_o}, 32'd1);
        wr(A_KICK, 32'hDEAD);
        chk("R8 kick clears irq", {31'd0, irq_o}, 32'd0);
        ticks(4);
        chk("R8 kick reloads (quiet)", {31'd0, irq_o}, 32'd0);
        ticks(1);
        chk("R8 kick reloads (expiry)", {31'd0, irq_o}, 32'd1);
        wr(A_LOCK, 32'h1);
        wr(A_KICK, 32'h0);
        chk("R3 locked kick ignored", {31'd0, irq_o}, 32'd1);
        wr(A_LOCK, KEY);
    endtask

    task automatic t_stop();
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        chk("R9 stop drops irq", {31'd0, irq_o}, 32'd0);
        ticks(20);
        chk("R9 stopped irq quiet", {31'd0, irq_o}, 32'd0);
        chk("R9 stopped rst quiet", {31'd0, wdt_rst_o}, 32'd0);
    endtask

    task automatic t_kick_race();
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h1);
        ticks(2);
        chk("R12 enable restarts count", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        bus_addr  = A_KICK;
        bus_wdata = 32'h0;
        bus_we    = 1'b1;
        tick_en   = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        tick_en   = 1'b0;
        chk("R8 kick beats expiry", {31'd0, irq_o}, 32'd0);
        ticks(2);
        chk("R8 race reload quiet", {31'd0, irq_o}, 32'd0);
        ticks(1);
        chk("R8 race reload expiry", {31'd0, irq_o}, 32'd1);
    endtask

    task automatic t_reset_out();
        wr(A_CTRL, 32'h3);
        ticks(2);
        chk("R6 no reset before 2nd expiry", {31'd0, wdt_rst_o}, 32'd0);
        ticks(1);
        chk("R6 reset at 2nd expiry", {31'd0, wdt_rst_o}, 32'd1);
        wr(A_KICK, 32'h0);
        wr(A_CTRL, 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 reset sticky", {31'd0, wdt_rst_o}, 32'd1);
        do_reset();
        chk("R10 system reset clears", {31'd0, wdt_rst_o}, 32'd0);
        rd(A_LOCK, 32'd1, "R1 relocked after reset");
    endtask

    task automatic t_zero_and_reload();
        wr(A_LOCK, KEY);
        wr(A_LOAD, 32'd0);
        wr(A_CTRL, 32'h1);
        chk("R11 quiet before tick", {31'd0, irq_o}, 32'd0);
        ticks(1);
        chk("R11 zero load immediate irq", {31'd0, irq_o}, 32'd1);
        wr(A_CTRL, 32'h3);
        ticks(1);
        chk("R11 zero load immediate reset", {31'd0, wdt_rst_o}, 32'd1);
        do_reset();
        wr(A_LOCK, KEY);
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, 32'h1);
        ticks(5);
        wr(A_LOAD, 32'd3);
        ticks(3);
        chk("R12 load write restarts (quiet)", {31'd0, irq_o}, 32'd0);
        ticks(1);
        chk("R12 load write restarts (expiry)", {31'd0, irq_o}, 32'd1);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_lock();
        t_count();
        t_stop();
        t_kick_race();
        t_reset_out();
        t_zero_and_reload();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule